// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block steers a binary-search conversion against an external analog comparator. A start request arrives while the block is idle. The block then puts the sample-hold into hold and clears the result. It presents a trial code to the DAC one bit per clock, from the most significant bit down. After each trial it reads back one comparator bit. If the DAC code overshoots the input, the trial bit is dropped. Otherwise the bit is kept.

A length-select input, sampled with the start request, picks one of two conversion lengths. The full length resolves every bit. The short length resolves only the upper bits and leaves the lower bits at zero.

When the last trial is done, the block loads the final code into the result register in a single step and returns the sample-hold to sample mode. It then holds the status flag high for a fixed acquisition interval so that the input can settle again. The result can already be read during this interval. The block ignores start requests while it is busy.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is asserted, and in the idle state that follows it, busy_o is 0, hold_o is 0, result_o is 0 and dac_code_o is 0.
- R2: A start_i sampled high while busy_o is 0 makes busy_o and hold_o 1 and result_o 0 from the next cycle.
- R3: The first trial code after a start is the most significant bit alone (0x800 for 12 bits).
- R4: cmp_above_i = 1 means the current DAC code is above the input, and the bit under trial is then dropped. With cmp_above_i = 0 the bit is kept. For an input of 0..4095 a full conversion yields the input itself, and an input above 4095 yields 4095.
- R5: With short_i = 1 at the start, hold_o stays high for exactly SHORT_BITS (8) cycles. result_o then holds the upper 8 bits of the input, and its low 4 bits are 0.
- R6: With short_i = 0 at the start, hold_o stays high for exactly WIDTH (12) cycles.
- R7: A start_i that is high while busy_o is 1 has no effect. It does not change the trial count, the result, or the length of the acquisition interval, and no new conversion follows it.
- R8: After hold_o falls, busy_o stays high for exactly ACQ_CYCLES cycles, and the final result is already visible on result_o during all of them.
- R9: result_o stays 0 during the trials. The complete code appears in the same cycle that hold_o falls, and result_o does not change again until the next start.
- R10: hold_o is 1 only while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Conversion request, sampled on each clock edge |
| short_i | input | 1 | Selects the short cycle when high, sampled with start_i |
| cmp_above_i | input | 1 | Comparator result: 1 when the DAC code exceeds the input |
| dac_code_o | output | WIDTH | Trial code presented to the DAC |
| result_o | output | WIDTH | Conversion result |
| busy_o | output | 1 | Status: high from start until the acquisition interval ends |
| hold_o | output | 1 | Sample-hold control: 1 = hold, 0 = sample |

## Verification
- **Wrong bit pointer or lost length select:** hold_o stays high for the wrong number of cycles. The error shows at the end of the trials, at most 12 cycles after the start.
- **Wrong keep/drop decision:** result_o differs from the input in the cycle that hold_o falls.
- **Miscounted acquisition timer:** busy_o falls early or late. The error shows within ACQ_CYCLES cycles of that point.
- **Start not blocked while busy:** the trial count changes, a reloaded MSB pattern appears on dac_code_o, or result_o goes back to zero. Any of these shows by the next cycle or at the end of the conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_ACQ   = 2'd2
  } sar_state_e;

endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       last_trial_i,
  input  logic       acq_done_i,
  output sar_state_e state_o,
  output logic       accept_o
);

  sar_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)      state_d = ST_TRIAL;
      ST_TRIAL: if (last_trial_i) state_d = ST_ACQ;
      ST_ACQ:   if (acq_done_i)   state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && start_i;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_i,
  input  logic             short_i,
  input  logic             step_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] final_code_o,
  output logic             last_o
);

  localparam int LOW_BITS = WIDTH - SHORT_BITS;
  localparam logic [WIDTH-1:0] MSB_MASK   = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] STOP_LONG  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] STOP_SHORT = STOP_LONG << LOW_BITS;

  logic [WIDTH-1:0] code_q, code_d;
  logic [WIDTH-1:0] probe_q, probe_d;
  logic             short_q, short_d;
  logic [WIDTH-1:0] stop_mask;
  logic [WIDTH-1:0] decided;

  generate
    if (LOW_BITS > 0) begin : g_two_len
      assign stop_mask = short_q ? STOP_SHORT : STOP_LONG;
    end else begin : g_one_len
      assign stop_mask = STOP_LONG;
    end
  endgenerate

  assign last_o       = |(probe_q & stop_mask);
  assign decided      = cmp_above_i ? (code_q & ~probe_q) : code_q;
  assign final_code_o = decided;

  always_comb begin
    code_d  = code_q;
    probe_d = probe_q;
    short_d = short_q;
    if (seed_i) begin
      code_d  = MSB_MASK;
      probe_d = MSB_MASK;
      short_d = short_i;
    end else if (step_i) begin
      probe_d = probe_q >> 1;
      code_d  = last_o ? decided : (decided | (probe_q >> 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      probe_q <= '0;
      short_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      probe_q <= probe_d;
      short_q <= short_d;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = $clog2(ACQ_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(ACQ_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                   cnt_d = LOAD_VAL;
    else if (run_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             hold_o
);

  sar_state_e       state;
  logic             accept;
  logic             last_trial;
  logic             acq_done;
  logic             in_trial;
  logic             finish;
  logic [WIDTH-1:0] final_code;
  logic [WIDTH-1:0] result_q, result_d;

  sar_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .last_trial_i (last_trial),
    .acq_done_i   (acq_done),
    .state_o      (state),
    .accept_o     (accept)
  );

  assign in_trial = (state == ST_TRIAL);
  assign finish   = in_trial && last_trial;

  sar_trial_reg #(
    .WIDTH      (WIDTH),
    .SHORT_BITS (SHORT_BITS)
  ) u_trial (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed_i       (accept),
    .short_i      (short_i),
    .step_i       (in_trial),
    .cmp_above_i  (cmp_above_i),
    .code_o       (dac_code_o),
    .final_code_o (final_code),
    .last_o       (last_trial)
  );

  sar_acq_timer #(
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_acq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (finish),
    .run_i  (state == ST_ACQ),
    .done_o (acq_done)
  );

  always_comb begin
    result_d = result_q;
    if (accept)      result_d = '0;
    else if (finish) result_d = final_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end

  assign result_o = result_q;
  assign busy_o   = (state != ST_IDLE);
  assign hold_o   = in_trial;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             short_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             busy_o,
  input logic             hold_o
);

  localparam int LOW_BITS = WIDTH - SHORT_BITS;
  localparam int HW = $clog2(WIDTH + 1) + 1;
  localparam int AW = $clog2(ACQ_CYCLES + 1) + 1;
  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic          short_q;
  logic [HW-1:0] hold_seen;
  logic [AW-1:0] acq_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q   <= 1'b0;
      hold_seen <= '0;
      acq_seen  <= '0;
    end else begin
      if (!busy_o && start_i) short_q <= short_i;
      if (hold_o) hold_seen <= hold_seen + 1'b1;
      else        hold_seen <= '0;
      if (busy_o && !hold_o) acq_seen <= acq_seen + 1'b1;
      else if (!busy_o)      acq_seen <= '0;
    end
  end

  AST_START_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && hold_o && result_o == '0)); // R2

  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (dac_code_o == MSB_MASK)); // R3

  AST_HOLD_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> busy_o); // R10

  AST_TRIAL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> (int'(hold_seen) == (short_q ? SHORT_BITS : WIDTH))); // R6

  AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !hold_o && short_q) |-> (result_o[LOW_BITS-1:0] == '0)); // R5

  AST_ACQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (int'(acq_seen) == ACQ_CYCLES)); // R8

  AST_RESULT_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$fell(hold_o)) |-> $stable(result_o)); // R9

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !hold_o) |=> !hold_o); // R7

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
  .WIDTH      (WIDTH),
  .SHORT_BITS (SHORT_BITS),
  .ACQ_CYCLES (ACQ_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .short_i    (short_i),
  .dac_code_o (dac_code_o),
  .result_o   (result_o),
  .busy_o     (busy_o),
  .hold_o     (hold_o)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;

  localparam int WIDTH      = 12;
  localparam int SHORT_BITS = 8;
  localparam int ACQ_CYCLES = 100;
  localparam int FULL       = (1 << WIDTH) - 1;
  localparam int LOW_MASK   = (1 << (WIDTH - SHORT_BITS)) - 1;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic             short_i;
  logic             cmp_above;
  logic [WIDTH-1:0] dac_code;
  logic [WIDTH-1:0] result;
  logic             busy;
  logic             hold;
  int               vin_q;
  int               n_checks;
  int               n_fails;

  sar_conv_seq #(
    .WIDTH      (WIDTH),
    .SHORT_BITS (SHORT_BITS),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .short_i     (short_i),
    .cmp_above_i (cmp_above),
    .dac_code_o  (dac_code),
    .result_o    (result),
    .busy_o      (busy),
    .hold_o      (hold)
  );

  // behavioural comparator: high when the DAC code overshoots the input
  assign cmp_above = (int'(dac_code) > vin_q);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // one conversion; poke pulses start_i during the trials and during acquisition
  task automatic run_conv(input int vin, input bit sh, input bit poke);
    int exp;
    int hc;
    int ac;
    bit bad_trial_res;
    bit bad_acq_res;
    exp = (vin > FULL) ? FULL : vin;
    if (sh) exp = exp & ~LOW_MASK;
    vin_q = vin;
    @(negedge clk);
    start_i = 1'b1;
    short_i = sh;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "hold after start", int'(hold), 1);
    chk("R3", "first trial code", int'(dac_code), 1 << (WIDTH - 1));
    hc = 0;
    bad_trial_res = 1'b0;
    while (hold === 1'b1) begin
      hc++;
      if (result !== '0) bad_trial_res = 1'b1;
      if (poke && hc == 3) begin start_i = 1'b1; short_i = ~sh; end
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R9", "result zero during trials", int'(bad_trial_res), 0);
    if (sh) chk("R5", "short trial count", hc, SHORT_BITS);
    else    chk("R6", "full trial count", hc, WIDTH);
    chk(sh ? "R5" : "R4", "result at hold fall", int'(result), exp);
    chk("R8", "busy at hold fall", int'(busy), 1);
    ac = 0;
    bad_acq_res = 1'b0;
    while (busy === 1'b1) begin
      ac++;
      if (int'(result) != exp) bad_acq_res = 1'b1;
      if (hold !== 1'b0) bad_acq_res = 1'b1;
      start_i = (poke && ac == 5);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R8", "acquisition length", ac, ACQ_CYCLES);
    chk("R8", "result steady in acquisition", int'(bad_acq_res), 0);
    @(negedge clk);
    chk(poke ? "R7" : "R10", "idle busy after end", int'(busy), 0);
    chk(poke ? "R7" : "R10", "idle hold after end", int'(hold), 0);
    chk("R9", "result kept after end", int'(result), exp);
  endtask

  task automatic test_reset_mid();
    vin_q = 1000;
    @(negedge clk);
    start_i = 1'b1;
    short_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "hold in reset", int'(hold), 0);
    chk("R1", "result in reset", int'(result), 0);
    chk("R1", "dac in reset", int'(dac_code), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy idle after reset", int'(busy), 0);
    chk("R1", "result idle after reset", int'(result), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual run still active, expected completion");
    summary();
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    vin_q    = 0;
    start_i  = 1'b0;
    short_i  = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy at reset", int'(busy), 0);
    chk("R1", "hold at reset", int'(hold), 0);
    chk("R1", "result at reset", int'(result), 0);
    chk("R1", "dac at reset", int'(dac_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_conv(1234, 1'b0, 1'b0);   // R4 mixed pattern
    run_conv(0,    1'b0, 1'b0);   // R4 every bit dropped
    run_conv(4095, 1'b0, 1'b0);   // R4 every bit kept
    run_conv(2048, 1'b0, 1'b0);   // R4 major carry upper side
    run_conv(2047, 1'b0, 1'b0);   // R4 major carry lower side
    run_conv(5000, 1'b0, 1'b0);   // R4 above full scale
    run_conv('hABC, 1'b1, 1'b0);  // R5 short cycle
    run_conv('h00F, 1'b1, 1'b0);  // R5 only low bits set
    run_conv(4095, 1'b1, 1'b0);   // R5 short full scale
    run_conv('hA5A, 1'b0, 1'b1);  // R7 restart attempts on full cycle
    run_conv('h3C7, 1'b1, 1'b1);  // R7 restart attempts on short cycle
    test_reset_mid();             // R1
    run_conv(777, 1'b0, 1'b0);    // R4 after reset
    summary();
    $finish;
  end

endmodule